// File: doc/BRIEF.md
# Condition-Code Skip Evaluator

This block decides whether a processor skips the instruction that follows a skip-class instruction. When the sequencer asserts a strobe, the block captures the 16-bit instruction word together with the accumulator (A), the Q register, eight sense switches and four condition toggles: zero, plus, minus and overflow. One cycle later it returns a single-cycle skip pulse. It never writes any register, and the only thing it produces is that pulse.

Every named condition test is an alias of one 4-bit mask. "Equal" is the same test as zero, "greater" the same as minus, "less" and "about to overflow" the same as plus, "not about to overflow" the same as zero. Compound names such as "not zero" or "not overflow" are masks with several bits set. The block ANDs that mask with the toggles instead of decoding each mnemonic as its own comparison. The other skip instructions test the sign of A, the low bit of A or Q, or the sense switches under an 8-bit mask. Any instruction word outside the skip class produces no pulse.

Bit numbering in this brief is the hardware numbering: bit 15 is the most significant bit and bit 0 the least significant.

Top module: `skip_evaluator`

## Requirements
- R1: While `rst_n` is low, `skip_pulse` is 0 at every rising edge, even if a strobe that would skip is present at that edge.
- R2: A word with bits [15:4] = 12'h2F0 is a condition-code skip. Its mask is bits [3:0], with zero at bit 3, plus at bit 2, minus at bit 1 and overflow at bit 0. It skips when any toggle selected by the mask is 1. Compound masks such as 4'b0111 and 4'b1110 follow the same rule.
- R3: A condition-code mask of 4'b1111 always skips, even when all toggles are 0. A mask of 4'b0000 never skips, even when all toggles are 1.
- R4: Word 16'h2800 skips exactly when A bit 15 is 1. The condition toggles have no effect on it.
- R5: Word 16'h2820 skips exactly when A bit 15 is 0. The condition toggles have no effect on it.
- R6: Word 16'h2840 skips exactly when A bit 0 is 0. Q has no effect on it.
- R7: Word 16'h2860 skips exactly when Q bit 0 is 0. A has no effect on it.
- R8: A word with bits [15:8] = 8'h27 skips when `sense_sw & instr_word[7:0]` is nonzero. `sense_sw[7]` is switch A and is paired with instruction bit 7, down to switch H at bit 0.
- R9: Every other instruction word gives no skip, whatever the operands and toggles are.
- R10: `skip_pulse` is registered. It is high only in the cycle after a rising edge at which `instr_strobe` was 1 and the decision was to skip. It is low after any edge without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_strobe | input | 1 | Capture the instruction and operands at this edge |
| instr_word | input | 16 | Instruction word |
| acc_word | input | 16 | Accumulator contents |
| q_word | input | 16 | Q register contents |
| sense_sw | input | 8 | Sense switch states, bit 7 = A through bit 0 = H |
| cc_zero | input | 1 | Zero toggle |
| cc_plus | input | 1 | Plus toggle |
| cc_minus | input | 1 | Minus toggle |
| cc_ovfl | input | 1 | Overflow toggle |
| skip_pulse | output | 1 | One-cycle skip decision |

## Verification
The bench builds the block with its default widths: a 16-bit word, a 4-bit condition mask and eight sense switches. At these sizes each single-toggle mask, the compound masks and the all-ones and all-zeros masks can be driven directly. So can each sense switch pairing, including switch A at the top of the mask field. Decode edges are probed just outside each opcode group (16'h2EFF, 16'h2F10, 16'h2801). Directed cases cover the pulse length, strobe-free cycles, back-to-back strobes and a strobe held under reset.

// File: rtl/skip_eval_pkg.sv
// Shared widths, opcode constants and the instruction class type for the
// skip evaluator. Assumes a 16-bit instruction word whose top bits select
// the skip group.
package skip_eval_pkg;
    localparam int WORD_W = 16;
    localparam int CC_N   = 4;
    localparam int SW_N   = 8;

    localparam int CC_HI_W = WORD_W - CC_N;
    localparam int SW_HI_W = WORD_W - SW_N;

    // Opcode prefixes and exact codes of the skip group.
    localparam logic [CC_HI_W-1:0] OP_CC_HI  = 12'h2F0;
    localparam logic [SW_HI_W-1:0] OP_SW_HI  = 8'h27;
    localparam logic [WORD_W-1:0]  OP_ACC_NEG = 16'h2800;
    localparam logic [WORD_W-1:0]  OP_ACC_POS = 16'h2820;
    localparam logic [WORD_W-1:0]  OP_ACC_EVN = 16'h2840;
    localparam logic [WORD_W-1:0]  OP_Q_EVN   = 16'h2860;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_CCMASK,
        CLS_ACC_NEG,
        CLS_ACC_POS,
        CLS_ACC_EVEN,
        CLS_Q_EVEN,
        CLS_SWITCH
    } skip_class_e;
endpackage

// File: rtl/skip_class_decode.sv
// Classifies an instruction word into one of the skip classes.
// Assumes the opcode constants of skip_eval_pkg. Words that match none
// of them map to CLS_NONE.
module skip_class_decode
    import skip_eval_pkg::*;
(
    input  logic [WORD_W-1:0] instr_word,
    output skip_class_e       cls
);
    // Match the prefix groups first, then the exact single-word codes.
    always_comb begin
        if (instr_word[WORD_W-1:CC_N] == OP_CC_HI)
            cls = CLS_CCMASK;
        else if (instr_word[WORD_W-1:SW_N] == OP_SW_HI)
            cls = CLS_SWITCH;
        else if (instr_word == OP_ACC_NEG)
            cls = CLS_ACC_NEG;
        else if (instr_word == OP_ACC_POS)
            cls = CLS_ACC_POS;
        else if (instr_word == OP_ACC_EVN)
            cls = CLS_ACC_EVEN;
        else if (instr_word == OP_Q_EVN)
            cls = CLS_Q_EVEN;
        else
            cls = CLS_NONE;
    end
endmodule

// File: rtl/skip_cc_match.sv
// Tests the condition-code toggles against a mask. Mask and toggles share
// bit order {zero, plus, minus, overflow}. An all-ones mask skips
// unconditionally. Assumes the caller qualifies the result by class.
module skip_cc_match
    import skip_eval_pkg::*;
(
    input  logic [CC_N-1:0] mask,
    input  logic [CC_N-1:0] toggles,
    output logic            hit
);
    logic [CC_N-1:0] sel;

    // One AND gate per condition toggle.
    for (genvar i = 0; i < CC_N; i++) begin : g_sel
        assign sel[i] = mask[i] & toggles[i];
    end

    // Any selected toggle, or the unconditional mask, gives a skip.
    assign hit = (&mask) | (|sel);

    // The zero mask must never report a hit.
    always_comb begin
        if (mask == '0)
            AST_ZERO_MASK_QUIET: assert (!hit); // R3
    end
endmodule

// File: rtl/skip_operand_test.sv
// Evaluates the operand-based skip tests: accumulator sign, accumulator
// and Q parity, and the sense-switch mask. Returns 0 for any class it does
// not own, including the condition-code class.
module skip_operand_test
    import skip_eval_pkg::*;
(
    input  skip_class_e     cls,
    input  logic            acc_sign,
    input  logic            acc_lsb,
    input  logic            q_lsb,
    input  logic [SW_N-1:0] sw_state,
    input  logic [SW_N-1:0] sw_mask,
    output logic            hit
);
    // Select the one test that belongs to the decoded class.
    always_comb begin
        unique case (cls)
            CLS_ACC_NEG:  hit = acc_sign;
            CLS_ACC_POS:  hit = !acc_sign;
            CLS_ACC_EVEN: hit = !acc_lsb;
            CLS_Q_EVEN:   hit = !q_lsb;
            CLS_SWITCH:   hit = |(sw_state & sw_mask);
            default:      hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/skip_evaluator.sv
// Top of the skip evaluator. Decodes the strobed instruction, runs the
// condition-code and operand tests combinationally, and registers a
// one-cycle skip pulse. Assumes the operands are valid in the strobe
// cycle. Reset is synchronous and active low.
module skip_evaluator
    import skip_eval_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_strobe,
    input  logic [WORD_W-1:0] instr_word,
    input  logic [WORD_W-1:0] acc_word,
    input  logic [WORD_W-1:0] q_word,
    input  logic [SW_N-1:0]   sense_sw,
    input  logic              cc_zero,
    input  logic              cc_plus,
    input  logic              cc_minus,
    input  logic              cc_ovfl,
    output logic              skip_pulse
);
    skip_class_e     cls;
    logic [CC_N-1:0] toggles;
    logic            cc_hit;
    logic            op_hit;
    logic            decide;
    logic            operand_bits_unused;

    assign toggles = {cc_zero, cc_plus, cc_minus, cc_ovfl};
    assign operand_bits_unused = ^{acc_word[WORD_W-2:1], q_word[WORD_W-1:1]};

    skip_class_decode u_decode (
        .instr_word (instr_word),
        .cls        (cls)
    );

    skip_cc_match u_cc (
        .mask    (instr_word[CC_N-1:0]),
        .toggles (toggles),
        .hit     (cc_hit)
    );

    skip_operand_test u_operand (
        .cls      (cls),
        .acc_sign (acc_word[WORD_W-1]),
        .acc_lsb  (acc_word[0]),
        .q_lsb    (q_word[0]),
        .sw_state (sense_sw),
        .sw_mask  (instr_word[SW_N-1:0]),
        .hit      (op_hit)
    );

    // Merge the two test paths by class.
    assign decide = (cls == CLS_CCMASK) ? cc_hit : op_hit;

    // Register the decision as a single pulse per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            skip_pulse <= 1'b0;
        else
            skip_pulse <= instr_strobe & decide;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_strobe |=> !skip_pulse); // R10

    AST_UNCOND_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_strobe && instr_word[WORD_W-1:CC_N] == OP_CC_HI
         && &instr_word[CC_N-1:0]) |=> skip_pulse); // R3

    AST_SIGN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_strobe && instr_word == OP_ACC_NEG)
        |=> skip_pulse == $past(acc_word[WORD_W-1])); // R4

    AST_SIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_strobe && instr_word == OP_ACC_POS)
        |=> skip_pulse != $past(acc_word[WORD_W-1])); // R5

    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_strobe && cls == CLS_NONE) |=> !skip_pulse); // R9
endmodule

// File: tb/tb_skip_evaluator.sv
module tb_skip_evaluator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_strobe = 1'b0;
    logic [15:0] instr_word = '0;
    logic [15:0] acc_word = '0;
    logic [15:0] q_word = '0;
    logic [7:0]  sense_sw = '0;
    logic [3:0]  cc = '0;
    logic        skip_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    skip_evaluator dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_strobe (instr_strobe),
        .instr_word   (instr_word),
        .acc_word     (acc_word),
        .q_word       (q_word),
        .sense_sw     (sense_sw),
        .cc_zero      (cc[3]),
        .cc_plus      (cc[2]),
        .cc_minus     (cc[1]),
        .cc_ovfl      (cc[0]),
        .skip_pulse   (skip_pulse)
    );

    // {instr, acc, q, switches, cc{z,p,m,o}, requirement, expected}
    localparam int NV = 30;
    localparam logic [64:0] VEC [0:NV-1] = '{
        {16'h2F08, 16'h0000, 16'h0000, 8'h00, 4'b1000, 4'd2,  1'b1}, // R2 zero
        {16'h2F08, 16'h0000, 16'h0000, 8'h00, 4'b0100, 4'd2,  1'b0}, // R2
        {16'h2F04, 16'h0000, 16'h0000, 8'h00, 4'b0100, 4'd2,  1'b1}, // R2 plus
        {16'h2F02, 16'h0000, 16'h0000, 8'h00, 4'b0010, 4'd2,  1'b1}, // R2 minus
        {16'h2F01, 16'h0000, 16'h0000, 8'h00, 4'b0001, 4'd2,  1'b1}, // R2 ovfl
        {16'h2F01, 16'h0000, 16'h0000, 8'h00, 4'b1110, 4'd2,  1'b0}, // R2
        {16'h2F07, 16'h0000, 16'h0000, 8'h00, 4'b1000, 4'd2,  1'b0}, // R2 not-zero
        {16'h2F07, 16'h0000, 16'h0000, 8'h00, 4'b0010, 4'd2,  1'b1}, // R2 not-zero
        {16'h2F0E, 16'h0000, 16'h0000, 8'h00, 4'b0001, 4'd2,  1'b0}, // R2 not-ovfl
        {16'h2F0F, 16'h0000, 16'h0000, 8'h00, 4'b0000, 4'd3,  1'b1}, // R3 uncond
        {16'h2F00, 16'h0000, 16'h0000, 8'h00, 4'b1111, 4'd3,  1'b0}, // R3 no-op
        {16'h2800, 16'h8000, 16'h0000, 8'h00, 4'b0000, 4'd4,  1'b1}, // R4
        {16'h2800, 16'h7FFF, 16'h0000, 8'h00, 4'b1111, 4'd4,  1'b0}, // R4
        {16'h2820, 16'h0000, 16'h0000, 8'h00, 4'b0000, 4'd5,  1'b1}, // R5
        {16'h2820, 16'hFFFF, 16'h0000, 8'h00, 4'b1111, 4'd5,  1'b0}, // R5
        {16'h2840, 16'h1234, 16'h0001, 8'h00, 4'b0000, 4'd6,  1'b1}, // R6
        {16'h2840, 16'h0001, 16'h0000, 8'h00, 4'b1111, 4'd6,  1'b0}, // R6
        {16'h2860, 16'h0001, 16'h0002, 8'h00, 4'b0000, 4'd7,  1'b1}, // R7
        {16'h2860, 16'h0000, 16'h0003, 8'h00, 4'b1111, 4'd7,  1'b0}, // R7
        {16'h2781, 16'h0000, 16'h0000, 8'h01, 4'b0000, 4'd8,  1'b1}, // R8 switch H
        {16'h2780, 16'h0000, 16'h0000, 8'h7F, 4'b1111, 4'd8,  1'b0}, // R8
        {16'h2780, 16'h0000, 16'h0000, 8'h80, 4'b0000, 4'd8,  1'b1}, // R8 switch A
        {16'h2700, 16'h0000, 16'h0000, 8'hFF, 4'b1111, 4'd8,  1'b0}, // R8 empty mask
        {16'h27FF, 16'h0000, 16'h0000, 8'h00, 4'b1111, 4'd8,  1'b0}, // R8 no switch
        {16'h2F10, 16'h8000, 16'h0000, 8'hFF, 4'b1111, 4'd9,  1'b0}, // R9
        {16'h2EFF, 16'h8000, 16'h0000, 8'hFF, 4'b1111, 4'd9,  1'b0}, // R9
        {16'h2801, 16'h8000, 16'h0000, 8'hFF, 4'b1111, 4'd9,  1'b0}, // R9
        {16'h2821, 16'h0000, 16'h0000, 8'hFF, 4'b1111, 4'd9,  1'b0}, // R9
        {16'h0000, 16'h0000, 16'h0000, 8'hFF, 4'b1111, 4'd9,  1'b0}, // R9
        {16'h2F1F, 16'h0000, 16'h0000, 8'hFF, 4'b1111, 4'd9,  1'b0}  // R9
    };

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s skip_pulse got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Drive one strobed instruction; the pulse shows after the next edge.
    task automatic strobe_once(input logic [15:0] iw, input logic [15:0] a,
                               input logic [15:0] q, input logic [7:0] sw,
                               input logic [3:0] c);
        @(negedge clk);
        instr_word = iw; acc_word = a; q_word = q; sense_sw = sw; cc = c;
        instr_strobe = 1'b1;
        @(negedge clk);
        instr_strobe = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1: reset state, and a skipping strobe held under reset.
        repeat (2) @(negedge clk);
        check("R1 reset idle", skip_pulse, 1'b0);
        strobe_once(16'h2F0F, '0, '0, '0, 4'b0000);
        check("R1 strobe under reset", skip_pulse, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk over every class.
        for (int i = 0; i < NV; i++) begin
            strobe_once(VEC[i][64:49], VEC[i][48:33], VEC[i][32:17],
                        VEC[i][16:9], VEC[i][8:5]);
            check($sformatf("R%0d vector %0d", VEC[i][4:1], i),
                  skip_pulse, VEC[i][0]);
        end

        // R10: pulse lasts one cycle.
        strobe_once(16'h2F0F, '0, '0, '0, 4'b0000);
        check("R10 pulse high", skip_pulse, 1'b1);
        @(negedge clk);
        check("R10 pulse ends", skip_pulse, 1'b0);

        // R10: skip condition present but no strobe.
        instr_word = 16'h2F0F; cc = 4'b1111;
        repeat (2) @(negedge clk);
        check("R10 no strobe", skip_pulse, 1'b0);

        // R10: back-to-back strobes, skip then no-op.
        instr_word = 16'h2F0F; instr_strobe = 1'b1;
        @(negedge clk);
        instr_word = 16'h2F00;
        check("R10 back-to-back first", skip_pulse, 1'b1);
        @(negedge clk);
        instr_strobe = 1'b0;
        check("R3 back-to-back no-op", skip_pulse, 1'b0);

        // R1: reset asserted right after a skipping strobe clears the pulse.
        strobe_once(16'h2800, 16'h8000, '0, '0, 4'b0000);
        check("R4 before reset", skip_pulse, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", skip_pulse, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end
endmodule